// File: doc/BRIEF.md
# Click and Round Task Scheduler

This block provides the fixed timing frame for a microprogrammed processor that runs one microinstruction in each processor cycle. Every cycle carries a phase label c1, c2 or c3, and the phases always run in that order. Each group of three phases is one click. Each group of five clicks is one round, and the clicks in a round are numbered 0 to 4.

Every click position in a round is owned by a set of I/O request lines, and that ownership is fixed by a parameter table. In phase c3 of each click, the block looks at the request lines owned by the click that comes next. The next click goes to the lowest-numbered owner that is requesting. If no owner is requesting, the click goes to the emulator task. The chosen task identifier then stays fixed for all three phases of the click. Downstream logic uses the phase number, the click index, the task identifier and a click-start strobe to pick the microprogram context and to time its own operations.

Top module: `click_round_sched`

## Requirements
- R1: While reset is asserted, the outputs show phase code 0 (c1), click index 0, task identifier 0 (emulator) and click_start = 1.
- R2: The phase code counts 0, 1, 2 and back to 0 (c1, c2, c3, c1), one step per clock edge, whatever the request inputs are.
- R3: The click index goes up by one only on the edge that leaves phase c3. It stays constant during the three phases of a click.
- R4: After click 4, the next click index is 0.
- R5: The task identifier is chosen only from the request lines sampled in phase c3 of the preceding click. It holds for all three phases of the click, so requests that change in c1 or c2 have no effect on it.
- R6: When request line k of the next click's owner mask is asserted in c3, and no lower line of that mask is asserted, the next click's task identifier is k+1.
- R7: When none of the next click's owner lines is asserted in c3, the task identifier is 0 (emulator), even if lines owned by other clicks are asserted.
- R8: When a click has several owner lines and more than one of them is asserted, the lowest-numbered asserted line wins. The default table gives click 0 line 0, click 1 line 1, click 2 lines 2 and 3, click 3 line 0, and click 4 line 3.
- R9: click_start is 1 in phase c1 and 0 in phases c2 and c3.
- R10: The first click after reset goes to the emulator (task 0), whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_req | input | NREQ (4) | Service request lines, one per I/O task |
| cycle_no | output | 2 | Phase code: 0 = c1, 1 = c2, 2 = c3 |
| click_idx | output | $clog2(NSLOT) (3) | Click index within the round |
| task_id | output | $clog2(NREQ+1) (3) | Task owning the current click: 0 = emulator, k+1 = I/O line k |
| click_start | output | 1 | High during phase c1 of every click |

## Verification
The phase code and the click index are registered, so they change one edge after the cycle they count. The bench steps a model of its own, one step per clock edge, and compares against it at each falling edge. A request is driven at the falling edge inside c3 and sampled on the next rising edge. Its effect on task_id is therefore due one edge later, in c1 of the next click, and the bench checks it there and again in c2 and c3 of that click. The bench changes the requests right after the c1 check, so the c2 and c3 checks also show that the late change had no effect on the current click.

// File: rtl/crs_pkg.sv
package crs_pkg;
  // Phase of a processor cycle inside one click; order is behaviour.
  typedef enum logic [1:0] {
    PH_C1 = 2'd0,
    PH_C2 = 2'd1,
    PH_C3 = 2'd2
  } phase_e;
endpackage

// File: rtl/crs_phase_ctr.sv
module crs_phase_ctr #(
  parameter int NSLOT = 5,
  localparam int CLK_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output crs_pkg::phase_e      phase_o,
  output logic [CLK_W-1:0]     click_o,
  output logic [CLK_W-1:0]     click_nxt_o,
  output logic                 last_o
);
  import crs_pkg::*;

  localparam logic [CLK_W-1:0] LAST_CLICK = CLK_W'(NSLOT - 1);

  phase_e            phase_q, phase_d;
  logic [CLK_W-1:0]  click_q, click_inc;
  logic              click_en;

  always_comb begin
    click_en  = (phase_q == PH_C3);
    phase_d   = (phase_q == PH_C3) ? PH_C1 : phase_e'(phase_q + 2'd1);
    click_inc = (click_q == LAST_CLICK) ? '0 : click_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_C1;
      click_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (click_en) click_q <= click_inc;
    end
  end

  assign phase_o     = phase_q;
  assign click_o     = click_q;
  assign click_nxt_o = click_inc;
  assign last_o      = click_en;

  // R2: phase order c1 -> c2 -> c3 -> c1
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_C3) |=> (phase_q == PH_C1));
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_C1) |=> (phase_q == PH_C2));
  // R3: click index frozen inside a click
  assert_click_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_C3) |=> $stable(click_q));
  // R4: round wrap
  assert_click_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_C3 && click_q == LAST_CLICK) |=> (click_q == '0));
endmodule

// File: rtl/crs_slot_arb.sv
module crs_slot_arb #(
  parameter int NREQ  = 4,
  parameter int NSLOT = 5,
  parameter logic [NSLOT*NREQ-1:0] SLOT_MASK = '0,
  localparam int CLK_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int TID_W = $clog2(NREQ + 1)
) (
  input  logic [CLK_W-1:0] slot_i,
  input  logic [NREQ-1:0]  req_i,
  output logic [TID_W-1:0] tid_o,
  output logic             hit_o
);
  logic [NREQ-1:0] mask_tbl [NSLOT];
  logic [NREQ-1:0] mask_sel, masked, gnt;

  for (genvar s = 0; s < NSLOT; s++) begin : g_tbl
    assign mask_tbl[s] = SLOT_MASK[s*NREQ +: NREQ];
  end

  always_comb begin
    mask_sel = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot_i == CLK_W'(s)) mask_sel = mask_tbl[s];
    end
    masked = req_i & mask_sel;
    gnt    = masked & (~masked + 1'b1);
  end

  always_comb begin
    tid_o = '0;
    for (int k = 0; k < NREQ; k++) begin
      if (gnt[k]) tid_o = TID_W'(k + 1);
    end
  end

  assign hit_o = |masked;

  // R8: at most one line granted, and only a requesting owner
  always_comb begin
    assert_one_grant_R8: assert ($onehot0(gnt));
    assert_grant_owned_R8: assert ((gnt & ~masked) == '0);
  end
endmodule

// File: rtl/crs_task_reg.sv
module crs_task_reg #(
  parameter int TID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TID_W-1:0] tid_i,
  output logic [TID_W-1:0] tid_o
);
  logic [TID_W-1:0] tid_q, tid_d;

  always_comb begin
    tid_d = load_i ? tid_i : tid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tid_q <= '0;
    else        tid_q <= tid_d;
  end

  assign tid_o = tid_q;

  // R5: task only changes at a click boundary
  assert_task_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(tid_q));
endmodule

// File: rtl/click_round_sched.sv
module click_round_sched #(
  parameter int NREQ  = 4,
  parameter int NSLOT = 5,
  parameter logic [NSLOT*NREQ-1:0] SLOT_MASK =
    {4'b1000, 4'b0001, 4'b1100, 4'b0010, 4'b0001},
  localparam int CLK_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int TID_W = $clog2(NREQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  io_req,
  output logic [1:0]       cycle_no,
  output logic [CLK_W-1:0] click_idx,
  output logic [TID_W-1:0] task_id,
  output logic             click_start
);
  import crs_pkg::*;

  phase_e            phase;
  logic [CLK_W-1:0]  click, click_nxt;
  logic              last;
  logic [TID_W-1:0]  tid_pick, tid_cur;
  logic              hit;

  crs_phase_ctr #(.NSLOT(NSLOT)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_o     (phase),
    .click_o     (click),
    .click_nxt_o (click_nxt),
    .last_o      (last)
  );

  crs_slot_arb #(.NREQ(NREQ), .NSLOT(NSLOT), .SLOT_MASK(SLOT_MASK)) u_arb (
    .slot_i (click_nxt),
    .req_i  (io_req),
    .tid_o  (tid_pick),
    .hit_o  (hit)
  );

  crs_task_reg #(.TID_W(TID_W)) u_task (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (last),
    .tid_i  (tid_pick),
    .tid_o  (tid_cur)
  );

  assign cycle_no    = phase;
  assign click_idx   = click;
  assign task_id     = tid_cur;
  assign click_start = (phase == PH_C1);

  // R7: no owner request in c3 -> emulator next click
  assert_idle_emu_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !hit) |=> (task_id == '0));
  // R6: owner request in c3 -> an I/O task next click
  assert_owner_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && hit) |=> (task_id != '0));
  // R9: strobe follows the c3 boundary and lasts one cycle
  assert_strobe_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> click_start);
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    click_start |=> !click_start);
endmodule

// File: tb/click_round_sched_bench.sv
`timescale 1ns/1ps
module click_round_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] io_req;
  logic [1:0] cycle_no;
  logic [2:0] click_idx;
  logic [2:0] task_id;
  logic       click_start;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  click_round_sched u_click_round_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_req      (io_req),
    .cycle_no    (cycle_no),
    .click_idx   (click_idx),
    .task_id     (task_id),
    .click_start (click_start)
  );

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    io_req = 4'b1111;
    repeat (3) @(negedge clk);
    check("R1 phase", int'(cycle_no), 0);
    check("R1 click", int'(click_idx), 0);
    check("R1 task", int'(task_id), 0);
    check("R1 strobe", int'(click_start), 1);
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++) begin
      check("R10 first click emulator", int'(task_id), 0);
      if (c < 2) @(negedge clk);
    end
  endtask

  task automatic t_counters();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 36; i++) begin
      io_req = 4'((i * 7) ^ (i >> 1));
      check("R2 phase order", int'(cycle_no), i % 3);
      check("R3 click index", int'(click_idx), (i / 3) % 5);
      check("R9 click_start", int'(click_start), (i % 3 == 0) ? 1 : 0);
      if (i == 15) check("R4 wrap to 0", int'(click_idx), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_slot(int slot, logic [3:0] rq, logic [3:0] late, int exp, string tag);
    int prev;
    prev = (slot + 4) % 5;
    while (!(cycle_no == 2'd2 && int'(click_idx) == prev)) @(negedge clk);
    io_req = rq;
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      check("R3 click of slot", int'(click_idx), slot);
      check(tag, int'(task_id), exp);
      if (c == 0) io_req = late;
      if (c > 0) check("R5 held despite late change", int'(task_id), exp);
      if (c < 2) @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_counters();
    t_slot(1, 4'b0010, 4'b0000, 2, "R6 owner line 1");
    t_slot(2, 4'b1100, 4'b0000, 3, "R8 shared slot lowest line");
    t_slot(3, 4'b0000, 4'b0001, 0, "R5 late request ignored");
    t_slot(4, 4'b1000, 4'b0111, 4, "R6 owner line 3");
    t_slot(0, 4'b0001, 4'b1110, 1, "R4 wrap and owner line 0");
    t_slot(1, 4'b1101, 4'b1111, 0, "R7 only foreign requests");
    t_slot(2, 4'b1000, 4'b0100, 4, "R8 only upper shared line");
    t_slot(3, 4'b0001, 4'b0000, 1, "R6 owner line 0 in slot 3");
    t_slot(4, 4'b0111, 4'b1000, 0, "R7 slot 4 idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule